// File: doc/BRIEF.md
# Serial Avionics Word Transmitter

This block sends one 32-bit or 25-bit avionics data word as a bipolar return-to-zero stream on two wires. A host loads the word over a 16-bit bus in two writes. The first write uses a shuffled field layout. The second write carries the middle data field. The host then raises a send request. The transmitter replaces the last bit of the word with a generated parity bit. It drives the word out label first. After the word it holds both wires low for a fixed gap, and only then will it accept the next word.

A separate control write, latched on the rising edge of a strobe, sets three options. The first picks the bit rate: one tenth or one eightieth of the clock. The second picks the word length. The third inverts the parity bit, so that a receiver's parity checker can be tested. The self-test bit of the control word has no effect on this block, and the line output stays active whatever its value.

Top module: `serial_word_tx`

## Requirements
- R1: After reset both line wires are low, busy is low, and neither half of the word is marked as written.
- R2: A rising edge of ctrl_strobe captures three control bits from bus_data. Bit 12 is parity invert, bit 13 is slow rate and bit 15 is short word. Holding the strobe high while the bus changes captures nothing further.
- R3: Bits are numbered 1 to 32 in send order. Bits 1..8 come from bus bits 7..0 of the first write, with bus bit 7 as bit 1. Bits 9..13 come from bus bits 11..15 of that write. Bits 30 and 31 come from bus bits 9 and 10. Bus bit 8 is not used. Bits 14..29 come from bus bits 0..15 of the second write. Bit 1 is sent first.
- R4: The last bit of the word is parity over all earlier bits. With parity invert at 0 the word as sent has an odd number of ones. With parity invert at 1 it has an even number.
- R5: A bit lasts 10 clock cycles when slow rate is 0, and 80 clock cycles when slow rate is 1.
- R6: For a 1, line_hi is high in the first half of the bit and line_lo stays low. For a 0, line_lo is high in the first half and line_hi stays low. Both wires are low in the second half. Each half is five tenths of the bit.
- R7: With short word at 0, 32 bits are sent (bits 1..31 then parity). With short word at 1, 25 bits are sent (bits 1..24 then parity).
- R8: After the last bit both wires stay low for four bit times. Busy is high from the cycle after the start edge until the gap ends, a total of (bits×10+40)×divider cycles.
- R9: A transmission starts on a clock edge with send_en high only when the block is idle and both halves have been written since the last start. Starting clears both written marks. A half stays marked until the start that uses it.
- R10: wr_first and wr_second are ignored while busy. The stored halves and written marks do not change.
- R11: Bus bit 5 of the control word (self-test) does not change the line output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, ten times the fast bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 16 | Host data bus |
| ctrl_strobe | input | 1 | Control word capture, on rising edge |
| wr_first | input | 1 | Write of the first (shuffled) half |
| wr_second | input | 1 | Write of the second half |
| send_en | input | 1 | Request to start transmission |
| line_hi | output | 1 | Line wire that pulses for a 1 |
| line_lo | output | 1 | Line wire that pulses for a 0 |
| busy | output | 1 | Word or gap in progress |

## Verification
The bench checks every cycle of whole words against a model built from the field mapping. It does this at both rates, at both lengths and with both parity senses. A design with a misrouted field or a reversed label would show a wrong pulse at a known bit. A design with parity over the wrong span would show a wrong last bit. A design that got the gap or busy length wrong would drop or hold busy one cycle off the computed edge.

The bench also holds the control strobe high while the bus changes; a design that captured on level would switch to the slow rate. It sends with only one half written, where a design that started anyway would raise busy. It writes both halves during a transmission and then asks to send; a design that accepted those writes would start a second word.

// File: rtl/serial_word_tx.sv
module serial_word_tx #(
  parameter int BUS_W         = 16,
  parameter int LONG_LEN      = 32,
  parameter int SHORT_LEN     = 25,
  parameter int TICKS_PER_BIT = 10,
  parameter int HIGH_TICKS    = 5,
  parameter int GAP_BITS      = 4,
  parameter int SLOW_DIV      = 8,
  parameter int CTL_PAR_BIT   = 12,
  parameter int CTL_RATE_BIT  = 13,
  parameter int CTL_LEN_BIT   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             ctrl_strobe,
  input  logic             wr_first,
  input  logic             wr_second,
  input  logic             send_en,
  output logic             line_hi,
  output logic             line_lo,
  output logic             busy
);
  localparam int IDX_W = $clog2(LONG_LEN + GAP_BITS);
  localparam int SEL_W = $clog2(LONG_LEN);
  localparam int PH_W  = $clog2(TICKS_PER_BIT);
  localparam int PRE_W = $clog2(SLOW_DIV);

  logic [BUS_W-2:0]    first_q;
  logic [BUS_W-1:0]    second_q;
  logic                have_first, have_second;
  logic                strobe_d;
  logic                par_inv_c, slow_c, short_c;
  logic                sending, slow_s, short_s;
  logic [LONG_LEN-1:0] ser, ser_next, raw;
  logic [PRE_W-1:0]    pre;
  logic [PH_W-1:0]     phase;
  logic [IDX_W-1:0]    idx, cur_len, last_idx;
  logic                tick, start, in_word, hot, cur_bit, par_acc;
  logic                unused_bus8;

  assign unused_bus8 = bus_data[8];

  always_comb begin
    raw = '0;
    for (int i = 0; i < 8; i++) raw[i] = first_q[7-i];
    for (int i = 0; i < 5; i++) raw[8+i] = first_q[10+i];
    raw[28:13] = second_q;
    raw[29]    = first_q[8];
    raw[30]    = first_q[9];
  end

  always_comb begin
    int lenm1;
    lenm1   = (short_c ? SHORT_LEN : LONG_LEN) - 1;
    par_acc = 1'b0;
    for (int i = 0; i < LONG_LEN; i++)
      if (i < lenm1) par_acc = par_acc ^ raw[i];
    for (int i = 0; i < LONG_LEN; i++)
      if (i < lenm1)       ser_next[i] = raw[i];
      else if (i == lenm1) ser_next[i] = ~par_acc ^ par_inv_c;
      else                 ser_next[i] = 1'b0;
  end

  assign start    = send_en && !sending && have_first && have_second;
  assign tick     = slow_s ? (pre == PRE_W'(SLOW_DIV - 1)) : 1'b1;
  assign cur_len  = short_s ? IDX_W'(SHORT_LEN) : IDX_W'(LONG_LEN);
  assign last_idx = cur_len + IDX_W'(GAP_BITS - 1);
  assign in_word  = sending && (idx < cur_len);
  assign hot      = in_word && (phase < PH_W'(HIGH_TICKS));
  assign cur_bit  = ser[idx[SEL_W-1:0]];
  assign line_hi  = hot && cur_bit;
  assign line_lo  = hot && !cur_bit;
  assign busy     = sending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q     <= '0;
      second_q    <= '0;
      have_first  <= 1'b0;
      have_second <= 1'b0;
      strobe_d    <= 1'b0;
      par_inv_c   <= 1'b0;
      slow_c      <= 1'b0;
      short_c     <= 1'b0;
      sending     <= 1'b0;
      slow_s      <= 1'b0;
      short_s     <= 1'b0;
      ser         <= '0;
      pre         <= '0;
      phase       <= '0;
      idx         <= '0;
    end else begin
      strobe_d <= ctrl_strobe;
      if (ctrl_strobe && !strobe_d) begin
        par_inv_c <= bus_data[CTL_PAR_BIT];
        slow_c    <= bus_data[CTL_RATE_BIT];
        short_c   <= bus_data[CTL_LEN_BIT];
      end
      if (!sending && wr_first) begin
        first_q    <= {bus_data[BUS_W-1:9], bus_data[7:0]};
        have_first <= 1'b1;
      end
      if (!sending && wr_second) begin
        second_q    <= bus_data;
        have_second <= 1'b1;
      end
      if (start) begin
        sending     <= 1'b1;
        have_first  <= 1'b0;
        have_second <= 1'b0;
        ser         <= ser_next;
        slow_s      <= slow_c;
        short_s     <= short_c;
        pre         <= '0;
        phase       <= '0;
        idx         <= '0;
      end else if (sending) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) begin
          if (phase == PH_W'(TICKS_PER_BIT - 1)) begin
            phase <= '0;
            if (idx == last_idx) sending <= 1'b0;
            else                 idx     <= idx + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!line_hi && !line_lo));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !have_first && !have_second));

  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && (wr_first || wr_second)) |=> ($stable(first_q) && $stable(second_q)));

  assert_rz_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_hi || line_lo) |-> (phase < PH_W'(HIGH_TICKS)));

  assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && $past(sending) && !$past(tick) && !$past(start)) |-> $stable(phase));

  assert_gap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && idx >= cur_len) |-> (!line_hi && !line_lo));
endmodule

// File: tb/test_serial_word_tx.sv
module test_serial_word_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_data = '0;
  logic        ctrl_strobe = 1'b0, wr_first = 1'b0, wr_second = 1'b0, send_en = 1'b0;
  logic        line_hi, line_lo, busy;
  int          n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  serial_word_tx i_serial_word_tx (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .ctrl_strobe(ctrl_strobe),
    .wr_first(wr_first), .wr_second(wr_second), .send_en(send_en),
    .line_hi(line_hi), .line_lo(line_lo), .busy(busy));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    bus_data = v; ctrl_strobe = 1'b1;
    @(negedge clk); ctrl_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_a(input logic [15:0] v);
    bus_data = v; wr_first = 1'b1;
    @(negedge clk); wr_first = 1'b0;
  endtask

  task automatic wr_b(input logic [15:0] v);
    bus_data = v; wr_second = 1'b1;
    @(negedge clk); wr_second = 1'b0;
  endtask

  // expected bits 1..32 from the R3 mapping, parity per R4, length per R7
  function automatic logic [32:1] model(input logic [15:0] a, input logic [15:0] b,
                                        input bit inv, input int n);
    logic [32:1] w;
    int ones;
    w = '0;
    for (int k = 1; k <= 8; k++) w[k] = a[8-k];
    for (int k = 9; k <= 13; k++) w[k] = a[k+2];
    for (int k = 14; k <= 29; k++) w[k] = b[k-14];
    w[30] = a[9];
    w[31] = a[10];
    ones = 0;
    for (int k = 1; k < n; k++) ones += int'(w[k]);
    w[n] = inv ? (ones % 2 == 1) : (ones % 2 == 0);
    for (int k = n + 1; k <= 32; k++) w[k] = 1'b0;
    return w;
  endfunction

  task automatic fire_and_watch(input logic [15:0] a, input logic [15:0] b,
                                input bit inv, input bit slow, input bit shrt, input string tag);
    logic [32:1] w;
    int n, dv, total, bad_line, bad_busy, act_l, exp_l, act_b, exp_b;
    n  = shrt ? 25 : 32;
    dv = slow ? 8 : 1;
    w  = model(a, b, inv, n);
    total = (n * 10 + 40) * dv;
    bad_line = 0; bad_busy = 0; act_l = 0; exp_l = 0; act_b = 0; exp_b = 0;
    send_en = 1'b1;
    @(posedge clk);
    for (int j = 0; j <= total + 1; j++) begin
      int t, bn, ph;
      logic eh, el, eb;
      @(negedge clk);
      send_en = 1'b0;
      t = j / dv; bn = t / 10; ph = t % 10;
      eh = (bn < n) && (ph < 5) && w[bn+1];
      el = (bn < n) && (ph < 5) && !w[bn+1];
      eb = (j < total);
      if ({line_hi, line_lo} !== {eh, el}) begin
        if (bad_line == 0) begin act_l = {line_hi, line_lo}; exp_l = {eh, el}; end
        bad_line++;
      end
      if (busy !== eb) begin
        if (bad_busy == 0) begin act_b = busy; exp_b = eb; end
        bad_busy++;
      end
    end
    chk(bad_line == 0, {tag, " waveform"}, act_l, exp_l);
    chk(bad_busy == 0, "R8 busy span and gap", act_b, exp_b);
  endtask

  task automatic t_reset();
    chk({line_hi, line_lo} == 2'b00, "R1 lines low", {line_hi, line_lo}, 0);
    chk(busy == 1'b0, "R1 busy low", busy, 0);
    send_en = 1'b1; @(negedge clk); send_en = 1'b0; @(negedge clk);
    chk(busy == 1'b0, "R1 no halves marked", busy, 0);
  endtask

  task automatic t_fast_odd();
    wr_ctrl(16'h0020); wr_a(16'hA5C3); wr_b(16'h1234);
    fire_and_watch(16'hA5C3, 16'h1234, 0, 0, 0, "R3 R4 R6 fast odd");
  endtask

  task automatic t_even();
    wr_ctrl(16'h1020); wr_a(16'hA5C3); wr_b(16'h1234);
    fire_and_watch(16'hA5C3, 16'h1234, 1, 0, 0, "R4 even parity");
  endtask

  task automatic t_slow();
    wr_ctrl(16'h2020); wr_a(16'h3C81); wr_b(16'hFFFF);
    fire_and_watch(16'h3C81, 16'hFFFF, 0, 1, 0, "R5 slow rate");
  endtask

  task automatic t_short();
    wr_ctrl(16'h8020); wr_a(16'h7E01); wr_b(16'h00F0);
    fire_and_watch(16'h7E01, 16'h00F0, 0, 0, 1, "R7 short word");
    wr_ctrl(16'h9020); wr_a(16'h0000); wr_b(16'h0000);
    fire_and_watch(16'h0000, 16'h0000, 1, 0, 1, "R7 short zero even");
  endtask

  task automatic t_selftest();
    wr_ctrl(16'h0000); wr_a(16'h5A5A); wr_b(16'hC3A1);
    fire_and_watch(16'h5A5A, 16'hC3A1, 0, 0, 0, "R11 self-test bit ignored");
  endtask

  task automatic t_level_strobe();
    wr_ctrl(16'h0020);
    bus_data = 16'h0020; ctrl_strobe = 1'b1; @(negedge clk);
    bus_data = 16'hB020; @(negedge clk); @(negedge clk);
    wr_a(16'h1F2E); wr_b(16'h8001);
    fire_and_watch(16'h1F2E, 16'h8001, 0, 0, 0, "R2 level held no recapture");
    ctrl_strobe = 1'b0; @(negedge clk);
  endtask

  task automatic t_one_half();
    wr_ctrl(16'h0020); wr_a(16'h4411);
    send_en = 1'b1; @(negedge clk); send_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 no start with one half", busy, 0);
    wr_b(16'h2222);
    fire_and_watch(16'h4411, 16'h2222, 0, 0, 0, "R9 half kept until start");
  endtask

  task automatic t_write_busy();
    wr_ctrl(16'h0020); wr_a(16'h0F0F); wr_b(16'hF00F);
    send_en = 1'b1; @(negedge clk); send_en = 1'b0;
    repeat (20) @(negedge clk);
    wr_a(16'hFFFF); wr_b(16'hFFFF);
    while (busy) @(negedge clk);
    send_en = 1'b1; @(negedge clk); send_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy writes ignored", busy, 0);
    chk({line_hi, line_lo} == 2'b00, "R10 lines idle", {line_hi, line_lo}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast_odd();
    t_even();
    t_slow();
    t_short();
    t_selftest();
    t_level_strobe();
    t_one_half();
    t_write_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule